// File: doc/BRIEF.md
# Calendar Register Window with Hold Buffers

This block sits on a byte-wide memory bus in front of a running calendar counter. The eight highest byte addresses of the address space form a clock window. The lowest of these eight is a control byte, and the remaining seven are user copies of seconds, minutes, hours, weekday, day of month, month and year. Every other address goes straight through to an external SRAM port. The live counter is never read or written directly by the bus. Software sees a separate set of user registers, and the counter keeps running behind them.

The user registers follow the counter on each one-second tick. Two hold bits in the control byte freeze them. The read hold gives software a consistent snapshot. The write hold lets software compose a new time, and when the write hold is released, that time is handed to the counter in a single load pulse. Bits of the clock bytes that carry no clock function are plain storage. A power-fail input shuts the bus out entirely and is echoed as an active-low flag.

Top module: `clkwin_window`

## Requirements
- R1: Window offset 0 (address 0x7FFF8) is the control byte, and offsets 1 to 7 are seconds, minutes, hours, weekday, date, month and year. A write stores the full byte, and a read returns it combinationally on `bus_rdata`. `bus_rdata` is 0 when no read is active.
- R2: Any address below 0x7FFF8 asserts `sram_sel`, passes address and write data through unchanged, raises `sram_we` on writes, and returns `sram_rdata` on reads. A window access never asserts `sram_sel`.
- R3: While neither hold bit is set, a `tick` cycle copies the clock bits of each `live_time` byte (byte k-1 feeds offset k) into user register k. The new value is readable in the following cycle.
- R4: While control bit 6 (read hold) is 1, ticks leave all user registers unchanged. They keep the values current at the edge that set the bit.
- R5: After the read hold returns to 0, the next tick refreshes all seven clock registers together.
- R6: While control bit 7 (write hold) is 1, ticks do not refresh. A control write that turns the bit from 1 to 0 makes `load_strobe` high for exactly the next cycle, with `load_time` carrying user bytes 1 to 7 (offset 1 in bits 7:0). Writing 0 while the bit is already 0 produces no strobe. When both holds are set, only clearing the write hold produces the strobe.
- R7: Clock-bit masks per offset are: seconds 0xFF, minutes 0x7F, hours 0x3F, weekday 0x47, date 0x3F, month 0x1F, year 0xFF. The control byte is never refreshed. Bits outside a mask keep the last written value and are never changed by a tick.
- R8: While `power_fail` is 1, writes have no effect, `sram_sel` stays 0, `bus_rdata` is 0, and `pf_n` is 0. `pf_n` is 1 otherwise.
- R9: When a tick and a bus write to a clock byte fall in the same cycle with no hold set, the written byte takes the bus value and every other clock byte refreshes.
- R10: After reset, all eight window bytes read 0 and `load_strobe` is 0.
- R11: A tick in the cycle in which `load_strobe` is high does not refresh the user registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| power_fail | input | 1 | Supply out of tolerance |
| pf_n | output | 1 | Active-low power-fail flag |
| sram_sel | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| tick | input | 1 | One-second update pulse from the counter |
| live_time | input | 56 | Live counter bytes, seconds in bits 7:0 |
| load_strobe | output | 1 | One-cycle transfer pulse to the counter |
| load_time | output | 56 | Time to load, seconds in bits 7:0 |

## Verification
Two of the block's functions can land on the same edge: the tick refresh and a bus write to a clock byte. The same holds for the tick refresh and the load pulse. The bench drives `tick` and a minutes write in one cycle, then reads every byte. The written byte must hold the bus value while its neighbours carry the new live time. It also raises `tick` in the exact cycle `load_strobe` is high, and then confirms that the freshly composed time is still visible and is refreshed only by the following tick.

// File: rtl/clkwin_pkg.sv
// Shared constants for the calendar register window.
// Assumes byte-wide data and an eight-entry window at the top of memory.
package clkwin_pkg;
    localparam int BYTE_W  = 8;
    localparam int NREG    = 8;
    localparam int IDX_W   = $clog2(NREG);
    localparam int TIME_W  = (NREG - 1) * BYTE_W;
    localparam int FLAT_W  = NREG * BYTE_W;
    localparam int WHOLD_B = 7;
    localparam int RHOLD_B = 6;

    // Clock-function bits of each window byte; the rest is plain storage.
    function automatic logic [BYTE_W-1:0] clock_mask(input int idx);
        case (idx)
            1:       return 8'hFF;
            2:       return 8'h7F;
            3:       return 8'h3F;
            4:       return 8'h47;
            5:       return 8'h3F;
            6:       return 8'h1F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/clkwin_decode.sv
// Address decode: splits bus accesses between the clock window and SRAM.
// Assumes the window occupies the NREG highest addresses; power-fail blocks all.
module clkwin_decode
    import clkwin_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              power_fail,
    output logic              win_wr,
    output logic              win_rd,
    output logic [IDX_W-1:0]  win_idx,
    output logic              sram_sel,
    output logic              sram_we,
    output logic              sram_rd
);
    logic in_win;
    logic live_acc;

    // Classify the current access.
    always_comb begin
        in_win   = &bus_addr[ADDR_W-1:IDX_W];
        live_acc = bus_sel && !power_fail;
        win_idx  = bus_addr[IDX_W-1:0];
        win_wr   = live_acc && in_win && bus_wr;
        win_rd   = live_acc && in_win && bus_rd && !bus_wr;
        sram_sel = live_acc && !in_win;
        sram_we  = sram_sel && bus_wr;
        sram_rd  = sram_sel && bus_rd && !bus_wr;
    end
endmodule

// File: rtl/clkwin_regs.sv
// User register file: control byte, seven clock bytes, refresh and load pulse.
// Assumes tick is a single-cycle pulse issued after the live counter advances.
module clkwin_regs
    import clkwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tick,
    input  logic [TIME_W-1:0] live_time,
    output logic [FLAT_W-1:0] user_flat,
    output logic              load_strobe,
    output logic [TIME_W-1:0] load_time
);
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] tbyte [1:NREG-1];
    logic              refresh;
    logic              ctrl_wr;

    // Refresh only when no hold is active and no transfer is under way.
    always_comb begin
        ctrl_wr = wr_en && (wr_idx == '0);
        refresh = tick && !ctrl_q[WHOLD_B] && !ctrl_q[RHOLD_B] && !load_strobe;
    end

    // Control byte: written by the bus only.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data;
    end

    // Transfer pulse on a write hold falling from 1 to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) load_strobe <= 1'b0;
        else load_strobe <= ctrl_wr && ctrl_q[WHOLD_B] && !wr_data[WHOLD_B];
    end

    assign user_flat[BYTE_W-1:0] = ctrl_q;

    for (genvar g = 1; g < NREG; g++) begin : g_clk
        localparam logic [BYTE_W-1:0] MASK = clock_mask(g);
        // Clock byte: bus write wins, otherwise masked refresh from the counter.
        always_ff @(posedge clk) begin
            if (!rst_n) tbyte[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g))) tbyte[g] <= wr_data;
            else if (refresh)
                tbyte[g] <= (tbyte[g] & ~MASK) | (live_time[(g-1)*BYTE_W +: BYTE_W] & MASK);
        end
        assign user_flat[g*BYTE_W +: BYTE_W]     = tbyte[g];
        assign load_time[(g-1)*BYTE_W +: BYTE_W] = tbyte[g];
    end
endmodule

// File: rtl/clkwin_rdmux.sv
// Read-data selection between the window bytes and SRAM, zero when idle.
// Assumes at most one of win_rd and sram_rd is high.
module clkwin_rdmux
    import clkwin_pkg::*;
(
    input  logic              win_rd,
    input  logic              sram_rd,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [FLAT_W-1:0] user_flat,
    input  logic [BYTE_W-1:0] sram_rdata,
    output logic [BYTE_W-1:0] rdata
);
    // Pick the source of the read byte.
    always_comb begin
        if (win_rd) rdata = user_flat[win_idx*BYTE_W +: BYTE_W];
        else if (sram_rd) rdata = sram_rdata;
        else rdata = '0;
    end
endmodule

// File: rtl/clkwin_window.sv
// Top: calendar register window in front of a live counter, SRAM elsewhere.
// Assumes the counter samples load_time while load_strobe is high.
module clkwin_window
    import clkwin_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              power_fail,
    output logic              pf_n,
    output logic              sram_sel,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_wdata,
    input  logic [7:0]        sram_rdata,
    input  logic              tick,
    input  logic [55:0]       live_time,
    output logic              load_strobe,
    output logic [55:0]       load_time
);
    logic              win_wr;
    logic              win_rd;
    logic              sram_rd;
    logic [IDX_W-1:0]  win_idx;
    logic [FLAT_W-1:0] user_flat;

    assign pf_n       = !power_fail;
    assign sram_addr  = bus_addr;
    assign sram_wdata = bus_wdata;

    clkwin_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .power_fail(power_fail), .win_wr(win_wr), .win_rd(win_rd), .win_idx(win_idx),
        .sram_sel(sram_sel), .sram_we(sram_we), .sram_rd(sram_rd)
    );

    clkwin_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(win_wr), .wr_idx(win_idx), .wr_data(bus_wdata),
        .tick(tick), .live_time(live_time), .user_flat(user_flat),
        .load_strobe(load_strobe), .load_time(load_time)
    );

    clkwin_rdmux u_rdmux (
        .win_rd(win_rd), .sram_rd(sram_rd), .win_idx(win_idx), .user_flat(user_flat),
        .sram_rdata(sram_rdata), .rdata(bus_rdata)
    );
endmodule

// File: rtl/clkwin_window_chk.sv
// Checker for the calendar register window, bound to the top module.
// Assumes it sees the internal window write enable and the user register image.
module clkwin_window_chk
    import clkwin_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              power_fail,
    input logic              sram_sel,
    input logic [7:0]        bus_rdata,
    input logic              load_strobe,
    input logic              win_wr,
    input logic [FLAT_W-1:0] user_flat
);
    function automatic logic [FLAT_W-1:0] spare_bits();
        logic [FLAT_W-1:0] s;
        s = '0;
        s[BYTE_W-1:0] = '1;
        for (int i = 1; i < NREG; i++) s[i*BYTE_W +: BYTE_W] = ~clock_mask(i);
        return s;
    endfunction
    localparam logic [FLAT_W-1:0] SPARE = spare_bits();

    logic whold, rhold;
    assign whold = user_flat[WHOLD_B];
    assign rhold = user_flat[RHOLD_B];

    a_r2_window_not_sram: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (&bus_addr[ADDR_W-1:IDX_W])) |-> !sram_sel);

    a_r8_power_fail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        power_fail |-> (!sram_sel && bus_rdata == 8'h00));

    a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);

    a_r6_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> $fell(whold));

    a_r6_fall_gives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(whold) |-> load_strobe);

    a_r4_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        ((whold || rhold) && !win_wr) |=> $stable(user_flat[FLAT_W-1:BYTE_W]));

    a_r11_strobe_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && !win_wr) |=> $stable(user_flat[FLAT_W-1:BYTE_W]));

    a_r7_spare_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(user_flat & SPARE));
endmodule

bind clkwin_window clkwin_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .power_fail(power_fail), .sram_sel(sram_sel), .bus_rdata(bus_rdata),
    .load_strobe(load_strobe), .win_wr(win_wr), .user_flat(user_flat)
);

// File: tb/clkwin_window_tb.sv
`timescale 1ns/1ps
module clkwin_window_tb;
    localparam int AW = 19;
    localparam logic [AW-1:0] BASE = 19'h7FFF8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic power_fail = 0;
    logic pf_n, sram_sel, sram_we;
    logic [AW-1:0] sram_addr;
    logic [7:0] sram_wdata;
    logic [7:0] sram_rdata = '0;
    logic tick = 0;
    logic [55:0] live_time = '0;
    logic load_strobe;
    logic [55:0] load_time;

    int n_chk = 0, n_fail = 0;
    logic [7:0] em [8];

    always #2.5 clk = ~clk;

    clkwin_window #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .power_fail(power_fail), .pf_n(pf_n), .sram_sel(sram_sel), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .tick(tick), .live_time(live_time), .load_strobe(load_strobe), .load_time(load_time)
    );

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            1: return 8'hFF; 2: return 8'h7F; 3: return 8'h3F; 4: return 8'h47;
            5: return 8'h3F; 6: return 8'h1F; 7: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [55:0] exp_load();
        logic [55:0] v;
        for (int i = 1; i < 8; i++) v[(i-1)*8 +: 8] = em[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic refresh_model();
        for (int i = 1; i < 8; i++)
            em[i] = (em[i] & ~mask_of(i)) | (live_time[(i-1)*8 +: 8] & mask_of(i));
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = BASE + AW'(idx); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (!power_fail) em[idx] = d;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = BASE + AW'(idx);
        #1 d = bus_rdata;
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1;
        if (em[0][7:6] == 2'b00) refresh_model();
        @(negedge clk);
        tick = 0;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            chk(tag, d, em[i]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        int unused_seed;
        unused_seed = $urandom(32'd1647);
        for (int i = 0; i < 8; i++) em[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R10: reset state
        chk("R10 strobe", load_strobe, 0);
        check_all("R10 reset bytes");

        // R3 / R7: refresh with clock masks (spare live bits ignored)
        live_time = {8'h24, 8'hF2, 8'hF1, 8'hC7, 8'hE3, 8'hD9, 8'h58};
        do_tick();
        check_all("R3 refresh");

        // R7: spare bits survive a tick
        wr(2, 8'hAA); wr(3, 8'hC5);
        live_time[15:8] = 8'h11; live_time[23:16] = 8'h04;
        do_tick();
        check_all("R7 spare kept");

        // R1 / R7: random byte read-back without ticks
        for (int k = 0; k < 20; k++) begin
            int idx;
            logic [7:0] v;
            idx = 1 + ($urandom % 7);
            v = 8'($urandom);
            wr(idx, v);
            rd(idx, d);
            chk("R1 readback", d, v);
        end

        // R4: read hold freezes the user copy
        wr(0, 8'h40);
        live_time = {8'h25, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        do_tick(); do_tick();
        check_all("R4 read hold");

        // R5: release, then the next tick refreshes
        wr(0, 8'h00);
        do_tick();
        check_all("R5 release refresh");

        // R6: write hold, compose, release -> strobe
        wr(0, 8'h80);
        live_time = {8'h30, 8'h09, 8'h09, 8'h09, 8'h09, 8'h09, 8'h09};
        do_tick();
        wr(1, 8'h30); wr(3, 8'h12);
        check_all("R6 write hold");
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = BASE; bus_wdata = 8'h00;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; em[0] = 8'h00;
        chk("R6 strobe high", load_strobe, 1);
        chk("R6 load time", load_time, exp_load());
        // R11: tick coincides with the strobe cycle
        live_time = {8'h31, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08};
        tick = 1;
        @(negedge clk);
        tick = 0;
        chk("R6 strobe single", load_strobe, 0);
        check_all("R11 no refresh in strobe cycle");
        do_tick();
        check_all("R11 later refresh");

        // R6: clearing an already clear write hold gives no strobe
        wr(0, 8'h00);
        chk("R6 no strobe", load_strobe, 0);

        // R6: both holds, write hold takes precedence
        wr(0, 8'hC0);
        live_time = {8'h32, 8'h07, 8'h07, 8'h07, 8'h07, 8'h07, 8'h07};
        do_tick();
        wr(0, 8'h40);
        chk("R6 strobe with read hold", load_strobe, 1);
        do_tick();
        check_all("R6 read hold after transfer");
        wr(0, 8'h00);

        // R9: tick and write to minutes in the same cycle
        live_time = {8'h33, 8'h06, 8'h15, 8'h02, 8'h11, 8'h33, 8'h44};
        @(negedge clk);
        tick = 1; bus_sel = 1; bus_wr = 1; bus_addr = BASE + 19'd2; bus_wdata = 8'h07;
        refresh_model();
        em[2] = 8'h07;
        @(negedge clk);
        tick = 0; bus_sel = 0; bus_wr = 0;
        check_all("R9 collision");

        // R8: power fail blocks everything
        power_fail = 1;
        #1 chk("R8 pf_n low", pf_n, 0);
        wr(1, 8'h55);
        rd(1, d);
        chk("R8 read blocked", d, 8'h00);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = 19'h00123; sram_rdata = 8'h5A;
        #1 chk("R8 sram blocked", sram_sel, 0);
        bus_sel = 0; bus_rd = 0;
        power_fail = 0;
        #1 chk("R8 pf_n high", pf_n, 1);
        check_all("R8 no write landed");

        // R1 / R2: random SRAM pass-through and window isolation
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] a;
            logic [7:0] v;
            logic w;
            a = AW'($urandom % 32'h7FFF8);
            v = 8'($urandom);
            w = 1'($urandom);
            @(negedge clk);
            bus_sel = 1; bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = v;
            sram_rdata = 8'($urandom);
            #1;
            chk("R2 sram_sel", sram_sel, 1);
            chk("R2 sram_we", sram_we, w);
            chk("R2 sram_addr", sram_addr, a);
            if (w) chk("R2 sram_wdata", sram_wdata, v);
            else chk("R2 rdata pass", bus_rdata, sram_rdata);
            bus_sel = 0; bus_wr = 0; bus_rd = 0;
            @(negedge clk);
            bus_sel = 1; bus_rd = 1; bus_addr = BASE + AW'($urandom % 8);
            #1 chk("R2 window no sram", sram_sel, 0);
            bus_sel = 0; bus_rd = 0;
        end
        check_all("R2 window untouched");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule